// File: doc/BRIEF.md
# Checked Serial Segment Loader

This block receives segment data for a display over a three-line serial bus: an enable line that frames a transfer, a burst clock whose rising edges sample the data line, and the data line itself. Every bus line is brought into the system clock through a synchroniser, and the edges are found there. While the enable line is high, the bits shift into a register. After the enable line drops, one more rising edge of the burst clock acts as the load strobe. At that strobe the data bits are copied into a segment latch bank, but only if the frame passed every check.

A frame has three parts, in this order: a zero start bit, `DATA_W` segment bits, and a bank-select bit. With `DUAL_BANK` set, the select bit picks one of two banks, one for each backplane. With `DUAL_BANK` clear there is only one bank, and it is written only when the select bit is one. A frame is dropped without any sign if it has the wrong bit count, a start bit of one, or a disturbed line. The block then waits for the next frame. The word length is a parameter, so one design serves both the 20-bit and the 32-bit segment variants.

Top module: `segload_rx`

## Requirements
- R1: A frame is accepted only if exactly `DATA_W`+2 burst-clock rising edges occur while the enable line is high. A frame with one edge fewer or one edge more changes no bank.
- R2: The first bit of a frame must be 0. A frame whose first bit is 1 is discarded.
- R3: With `DUAL_BANK`=1, a select bit (the last frame bit) of 1 writes `seg_bank_a` and a select bit of 0 writes `seg_bank_b`. The other bank keeps its value.
- R4: With `DUAL_BANK`=0, `seg_bank_a` is written only when the select bit is 1, and `seg_bank_b` stays all zero.
- R5: The transfer happens on the first burst-clock rising edge after the enable line has fallen. `load_pulse` is high for exactly one system cycle for each accepted transfer, in the same cycle that the bank shows the new data. There is no pulse for a discarded frame.
- R6: A frame is discarded if the data line changes while the burst clock is high, or if the enable line falls while the burst clock is high.
- R7: A discarded frame leaves both banks unchanged, and the next well-formed frame is accepted.
- R8: The first segment bit sent after the start bit lands in bit `DATA_W`-1 of the bank, and the last one lands in bit 0. A 1 means the segment is on.
- R9: A synchronous reset clears both banks, clears `load_pulse` and returns the receiver to idle.
- R10: Burst-clock pulses while the enable line is low and no frame is pending change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Serial enable line (asynchronous) |
| bus_clk | input | 1 | Serial burst clock (asynchronous) |
| bus_dat | input | 1 | Serial data line (asynchronous) |
| seg_bank_a | output | DATA_W | Segment latch bank A (backplane 1) |
| seg_bank_b | output | DATA_W | Segment latch bank B (backplane 2); all zero in single-bank mode |
| load_pulse | output | 1 | One-cycle marker of an accepted transfer |

## Verification
The bench drives a 32-bit two-bank instance and a 20-bit single-bank instance from one shared bus, so a frame of either length must be rejected by the instance it does not fit. A counter that does not compare exactly would load on a frame one bit short or one bit long. A walking-one sweep over every segment position catches a reversed or shifted bit order. Single glitches on the data line and early enable drops, each placed inside a high phase of the burst clock, target a checker that ignores disturbances: such a checker would load corrupt data. Burst-clock pulses outside any frame, and a select bit of 0 in single-bank mode, catch a design that writes a bank when it should not.

// File: rtl/segload_pkg.sv
`timescale 1ns/1ps
package segload_pkg;

    // Levels of the three bus lines after synchronisation
    typedef struct packed {
        logic en;
        logic clk;
        logic dat;
    } bus_t;

    // Events derived from two successive synchronised samples
    typedef struct packed {
        logic en_rise;
        logic en_fall;
        logic clk_rise;
        logic clk_held;   // burst clock high in this and the previous sample
        logic dat_chg;
    } bus_evt_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_ARMED = 2'd2
    } rx_state_e;

    // Counter width that holds 0 .. frame_bits+1 (saturating one past the frame)
    function automatic int cnt_width(input int frame_bits);
        return $clog2(frame_bits + 2);
    endfunction

endpackage

// File: rtl/segload_sync.sv
`timescale 1ns/1ps
module segload_sync
    import segload_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_t     raw,
    output bus_t     lvl,
    output bus_evt_t evt
);

    bus_t stg [STAGES];
    bus_t prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stg[STAGES-1];
    end

    assign lvl = stg[STAGES-1];

    always_comb begin
        evt.en_rise  = lvl.en  & ~prev.en;
        evt.en_fall  = ~lvl.en & prev.en;
        evt.clk_rise = lvl.clk & ~prev.clk;
        evt.clk_held = lvl.clk & prev.clk;
        evt.dat_chg  = lvl.dat ^ prev.dat;
    end

endmodule

// File: rtl/segload_frame.sv
`timescale 1ns/1ps
module segload_frame
    import segload_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int FRAME_BITS = DATA_W + 2,
    localparam int CNT_W = cnt_width(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_t              lvl,
    input  bus_evt_t          evt,
    output logic              commit,
    output logic              commit_sel,
    output logic [DATA_W-1:0] commit_data,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    rx_state_e             state;
    logic [FRAME_BITS-1:0] sreg;
    logic [CNT_W-1:0]      cnt;
    logic                  bad;
    logic                  disturb;

    // Data moving during a high burst clock is a disturbance
    assign disturb = evt.dat_chg & evt.clk_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            sreg  <= '0;
            cnt   <= '0;
            bad   <= 1'b0;
        end else if (evt.en_rise) begin
            state <= RX_SHIFT;
            cnt   <= '0;
            bad   <= 1'b0;
        end else begin
            unique case (state)
                RX_SHIFT: begin
                    if (evt.clk_rise) begin
                        sreg <= {sreg[FRAME_BITS-2:0], lvl.dat};
                        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
                        if (cnt == '0 && lvl.dat) bad <= 1'b1;
                    end
                    if (disturb) bad <= 1'b1;
                    if (evt.en_fall) begin
                        state <= RX_ARMED;
                        if (evt.clk_held) bad <= 1'b1;
                    end
                end
                RX_ARMED: begin
                    if (evt.clk_rise) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        commit      = (state == RX_ARMED) && evt.clk_rise && !evt.en_rise &&
                      !lvl.en && !bad && (cnt == CNT_FULL);
        commit_sel  = sreg[0];
        commit_data = sreg[DATA_W:1];
    end

    assign bit_cnt = cnt;

endmodule

// File: rtl/segload_banks.sv
`timescale 1ns/1ps
module segload_banks #(
    parameter int DATA_W    = 32,
    parameter bit DUAL_BANK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              commit_sel,
    input  logic [DATA_W-1:0] commit_data,
    output logic [DATA_W-1:0] bank_a,
    output logic [DATA_W-1:0] bank_b,
    output logic              load_pulse
);

    logic wr_a;
    logic wr_b;

    generate
        if (DUAL_BANK) begin : g_dual
            assign wr_a = commit & commit_sel;
            assign wr_b = commit & ~commit_sel;
        end else begin : g_single
            assign wr_a = commit & commit_sel;
            assign wr_b = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_a     <= '0;
            bank_b     <= '0;
            load_pulse <= 1'b0;
        end else begin
            load_pulse <= wr_a | wr_b;
            if (wr_a) bank_a <= commit_data;
            if (wr_b) bank_b <= commit_data;
        end
    end

endmodule

// File: rtl/segload_rx.sv
`timescale 1ns/1ps
module segload_rx
    import segload_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit DUAL_BANK   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_clk,
    input  logic              bus_dat,
    output logic [DATA_W-1:0] seg_bank_a,
    output logic [DATA_W-1:0] seg_bank_b,
    output logic              load_pulse
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = cnt_width(FRAME_BITS);

    bus_t              bus_raw;
    bus_t              bus_lvl;
    bus_evt_t          bus_evt;
    logic              en_lvl;
    logic              commit;
    logic              commit_sel;
    logic [DATA_W-1:0] commit_data;
    logic [CNT_W-1:0]  bit_cnt;

    assign bus_raw = '{en: bus_en, clk: bus_clk, dat: bus_dat};
    assign en_lvl  = bus_lvl.en;

    segload_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (bus_raw),
        .lvl (bus_lvl),
        .evt (bus_evt)
    );

    segload_frame #(.DATA_W(DATA_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .lvl         (bus_lvl),
        .evt         (bus_evt),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .bit_cnt     (bit_cnt)
    );

    segload_banks #(.DATA_W(DATA_W), .DUAL_BANK(DUAL_BANK)) u_banks (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .bank_a      (seg_bank_a),
        .bank_b      (seg_bank_b),
        .load_pulse  (load_pulse)
    );

endmodule

// File: rtl/segload_rx_chk.sv
`timescale 1ns/1ps
module segload_rx_chk #(
    parameter int DATA_W    = 32,
    parameter bit DUAL_BANK = 1'b1,
    parameter int CNT_W     = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              en_s,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [DATA_W-1:0] bank_a,
    input logic [DATA_W-1:0] bank_b,
    input logic              load_pulse
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W + 2);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    AST_ACCEPT_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $past(bit_cnt) == FULL);                         // R1

    AST_LOAD_AFTER_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> !$past(en_s));                                   // R5

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);                                    // R5

    AST_BANK_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_pulse |-> $stable(bank_a));                               // R7

    AST_BANK_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_pulse |-> $stable(bank_b));                               // R7

    AST_SINGLE_B_ZERO: assert property (@(posedge clk) disable iff (rst)
        !DUAL_BANK |-> bank_b == '0);                                   // R4

    always @(negedge clk) begin
        if (rst_d) begin
            AST_RESET_CLEARS: assert (bank_a == '0 && bank_b == '0 && !load_pulse); // R9
        end
    end

endmodule

bind segload_rx segload_rx_chk #(
    .DATA_W    (DATA_W),
    .DUAL_BANK (DUAL_BANK),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_s       (en_lvl),
    .bit_cnt    (bit_cnt),
    .bank_a     (seg_bank_a),
    .bank_b     (seg_bank_b),
    .load_pulse (load_pulse)
);

// File: tb/segload_rx_tb.sv
`timescale 1ns/1ps
module segload_rx_tb;

    localparam int WD = 32;   // two-bank instance
    localparam int WS = 20;   // single-bank instance
    localparam int H  = 8;    // system cycles per bus half phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;

    logic [WD-1:0] d_a, d_b;
    logic [WS-1:0] s_a, s_b;
    logic          d_pulse, s_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int pc_d = 0, pc_s = 0;

    logic [WD-1:0] exp_da = '0, exp_db = '0;
    logic [WS-1:0] exp_sa = '0;
    int            exp_pd = 0, exp_ps = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    segload_rx #(.DATA_W(WD), .DUAL_BANK(1'b1)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_clk(bus_clk), .bus_dat(bus_dat),
        .seg_bank_a(d_a), .seg_bank_b(d_b), .load_pulse(d_pulse)
    );

    segload_rx #(.DATA_W(WS), .DUAL_BANK(1'b0)) u_dut_s (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_clk(bus_clk), .bus_dat(bus_dat),
        .seg_bank_a(s_a), .seg_bank_b(s_b), .load_pulse(s_pulse)
    );

    always @(negedge clk) begin
        if (d_pulse) pc_d <= pc_d + 1;
        if (s_pulse) pc_s <= pc_s + 1;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Build a frame: bit 0 is sent first
    function automatic logic [63:0] mk(input int w, input logic [31:0] seg,
                                       input logic sel, input logic lead);
        logic [63:0] b = '0;
        b[0] = lead;
        for (int k = 0; k < w; k++) b[1+k] = seg[w-1-k];
        b[w+1] = sel;
        return b;
    endfunction

    // Expected result of a frame for each instance
    task automatic predict(input int nb, input logic [63:0] b, input bit glitch);
        logic [WD-1:0] vd;
        logic [WS-1:0] vs;
        if (!glitch && nb == WD + 2 && b[0] == 1'b0) begin
            for (int k = 0; k < WD; k++) vd[WD-1-k] = b[1+k];
            if (b[WD+1]) exp_da = vd; else exp_db = vd;
            exp_pd++;
        end
        if (!glitch && nb == WS + 2 && b[0] == 1'b0 && b[WS+1]) begin
            for (int k = 0; k < WS; k++) vs[WS-1-k] = b[1+k];
            exp_sa = vs;
            exp_ps++;
        end
    endtask

    // gdat: bit index whose high phase carries a data glitch (-1 none)
    // gen : drop enable during the high phase of the last bit
    task automatic send(input int nb, input logic [63:0] b, input int gdat, input bit gen);
        bus_en = 1'b1; wt(H);
        for (int i = 0; i < nb; i++) begin
            bus_dat = b[i]; wt(H);
            bus_clk = 1'b1;
            if (i == gdat) begin
                wt(3); bus_dat = ~bus_dat; wt(3); bus_dat = ~bus_dat; wt(H - 6);
            end else begin
                wt(H);
            end
            if (gen && i == nb - 1) begin
                bus_en = 1'b0; wt(H);
            end
            bus_clk = 1'b0; wt(H);
        end
        bus_en = 1'b0; wt(H);
        bus_clk = 1'b1; wt(H);      // load strobe
        bus_clk = 1'b0; wt(2 * H);
        predict(nb, b, (gdat >= 0) || gen);
    endtask

    task automatic check_all(input string req);
        chk(req, "two-bank A",   d_a, exp_da);
        chk(req, "two-bank B",   d_b, exp_db);
        chk(req, "two-bank pulses", pc_d, exp_pd);
        chk(req, "single A",     32'(s_a), 32'(exp_sa));
        chk(req, "single B",     32'(s_b), 32'd0);
        chk(req, "single pulses", pc_s, exp_ps);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wt(4); rst = 1'b0; wt(4);
        check_all("R9");                                   // reset state

        // R3: bank select, both directions
        send(WD+2, mk(WD, 32'hA5C3_0F96, 1'b1, 1'b0), -1, 1'b0); check_all("R3");
        send(WD+2, mk(WD, 32'h1234_5678, 1'b0, 1'b0), -1, 1'b0); check_all("R3");
        send(WD+2, mk(WD, 32'hFFFF_FFFF, 1'b1, 1'b0), -1, 1'b0); check_all("R3");

        // R4: single-bank, select 1 writes, select 0 ignored
        send(WS+2, mk(WS, 32'h000B_EEF1, 1'b1, 1'b0), -1, 1'b0); check_all("R4");
        send(WS+2, mk(WS, 32'h0005_5555, 1'b0, 1'b0), -1, 1'b0); check_all("R4");

        // R1: off-by-one counts
        send(WD+1, mk(WD, 32'h0F0F_0F0F, 1'b1, 1'b0), -1, 1'b0); check_all("R1");
        send(WD+3, mk(WD, 32'h0F0F_0F0F, 1'b0, 1'b0), -1, 1'b0); check_all("R1");
        send(WS+1, mk(WS, 32'h000C_3333, 1'b1, 1'b0), -1, 1'b0); check_all("R1");

        // R2: leading one
        send(WD+2, mk(WD, 32'hDEAD_BEEF, 1'b1, 1'b1), -1, 1'b0); check_all("R2");
        send(WS+2, mk(WS, 32'h0001_2345, 1'b1, 1'b1), -1, 1'b0); check_all("R2");

        // R6: disturbances
        send(WD+2, mk(WD, 32'hCAFE_F00D, 1'b0, 1'b0), 10, 1'b0); check_all("R6");
        send(WD+2, mk(WD, 32'hCAFE_F00D, 1'b1, 1'b0), -1, 1'b1); check_all("R6");
        send(WS+2, mk(WS, 32'h000F_0F0F, 1'b1, 1'b0), 0, 1'b0);  check_all("R6");

        // R7: recovery after discard
        send(WD+2, mk(WD, 32'h8000_0001, 1'b0, 1'b0), -1, 1'b0); check_all("R7");

        // R10: stray burst clocks with enable low
        for (int i = 0; i < 5; i++) begin
            bus_dat = i[0]; wt(H); bus_clk = 1'b1; wt(H); bus_clk = 1'b0; wt(H);
        end
        wt(H); check_all("R10");

        // R5: one pulse per accepted load, checked after every frame above; one more
        send(WS+2, mk(WS, 32'h000A_0005, 1'b1, 1'b0), -1, 1'b0); check_all("R5");

        // R8: walking one over every segment position of both widths
        for (int k = 0; k < WD; k++) begin
            send(WD+2, mk(WD, 32'd1 << k, k[0], 1'b0), -1, 1'b0); check_all("R8");
        end
        for (int k = 0; k < WS; k++) begin
            send(WS+2, mk(WS, 32'd1 << k, 1'b1, 1'b0), -1, 1'b0); check_all("R8");
        end

        // R9: reset in the middle of operation clears the banks
        rst = 1'b1; wt(4); rst = 1'b0; wt(2);
        exp_da = '0; exp_db = '0; exp_sa = '0;
        check_all("R9");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule